// File: doc/BRIEF.md
# Shared-RAM Host Bus Interface

This block is the slave port through which a 16-bit host processor reaches a 16K-word shared memory and a small register file. The host frames each access with an active-low chip select and an active-low data strobe, and drives a read/write line, a 14-bit word address and a 16-bit write bus. The block captures the access when the strobe falls. It then competes for the shared memory port against an internal memory client. The client normally wins a conflict, but the host is never refused for more than a bounded number of cycles. Register accesses do not arbitrate.

Two static straps adapt the block to different hosts. The polarity strap picks which level of the read/write line means write. The wait strap picks between two modes. In acknowledged mode, an active-low READY handshake tells the host that its write was taken or its read data is valid. In zero-wait mode, the host drops its strobe at once. READY then rises to show that a transfer is still pending, and each read returns the data that the previous read fetched.

The control is a four-state machine:
- `S_IDLE` waits for a strobe fall. `S_IDLE -> S_ARB` happens on a captured start.
- `S_ARB` holds the access until it is served: at once for a register, on a host grant for memory. From `S_ARB`, a read goes to `S_RDLAT`. A write goes to `S_ACK` in acknowledged mode, or back to `S_IDLE` in zero-wait mode.
- `S_RDLAT` loads the read holding register. It then goes to `S_ACK` in acknowledged mode, or to `S_IDLE` in zero-wait mode.
- `S_ACK` drives READY low until the strobe is seen high. It then goes back to `S_IDLE`.

Top module: `shif_top`

## Requirements
- R1: `mr_sel`=1 selects the memory, addressed by all 14 bits of `addr` through the memory port. `mr_sel`=0 selects register `addr[2:0]` of 8 registers. The upper address bits are ignored for registers, and a register access never touches the memory.
- R2: With `pol_strap`=0, `rw`=0 means write and `rw`=1 means read. With `pol_strap`=1, `rw`=1 means write and `rw`=0 means read.
- R3: An access starts at the first clock edge at which `strb_n` is seen low after having been high, with `sel_n` low and the block idle. Address, direction, target and write data are captured at that edge. Later bus changes, and strobe falls while the block is busy, have no effect.
- R4: In acknowledged mode (`zw_strap`=1), a write drives `ready_n` low starting 1 cycle after the host grant. `ready_n` stays low while the strobe stays low, and is high again 1 cycle after the strobe is released.
- R5: In acknowledged mode, a read drives `ready_n` low 2 cycles after the grant, with `rdata` already holding the addressed word.
- R6: In zero-wait mode (`zw_strap`=0), `ready_n` rests low whenever no transfer is pending or the strobe is still held low. It is high while the strobe is released and the transfer is unfinished. It returns low 1 cycle after the grant for a write, or 2 cycles after the grant for a read.
- R7: `rdata` changes only when a read completes. In zero-wait mode, the value a host sees during its read strobe is therefore the word fetched by the previous read.
- R8: When both the host and the client want the memory in the same cycle, the client is granted (`cl_gnt`=1). The host is denied at most MAX_WAIT=4 consecutive cycles and is granted in the next one. A register access counts as granted in its first cycle.
- R9: Register writes and reads take effect without arbitration, and every register resets to 0.
- R10: After reset, `rdata` is 0 and `ready_n` is high in acknowledged mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| zw_strap | input | 1 | 1 = acknowledged mode, 0 = zero-wait mode |
| pol_strap | input | 1 | Read/write sense select |
| sel_n | input | 1 | Active-low chip select |
| strb_n | input | 1 | Active-low data strobe |
| rw | input | 1 | Read/write line, sense set by `pol_strap` |
| mr_sel | input | 1 | 1 = memory, 0 = register file |
| addr | input | 14 | Host word address |
| wdata | input | 16 | Host write data |
| rdata | output | 16 | Read holding register |
| ready_n | output | 1 | Active-low handshake |
| cl_req | input | 1 | Internal client memory request |
| cl_we | input | 1 | Internal client write enable |
| cl_addr | input | 14 | Internal client address |
| cl_wdata | input | 16 | Internal client write data |
| cl_gnt | output | 1 | Client granted this cycle |
| cl_rdata | output | 16 | Memory read data for the client |
| mem_en | output | 1 | Memory port enable |
| mem_we | output | 1 | Memory port write enable |
| mem_addr | output | 14 | Memory port address |
| mem_wdata | output | 16 | Memory port write data |
| mem_rdata | input | 16 | Memory read data, valid 1 cycle after a read enable |

## Verification
Each access is counted from the negative clock edge at which the bench lowers the strobe. The cycle of the host grant follows from a bench model of the client requests and the wait limit. From that cycle, `ready_n` is due low at the following negative edge for a write, and one edge later for a read. The bench samples `ready_n` and `rdata` only at negative edges and compares the edge index with that expectation. In zero-wait mode, `rdata` is checked during the strobe against the previous read's value, and again after completion against the new one.

// File: rtl/shif_pkg.sv
package shif_pkg;
    parameter int ADDR_W = 14;
    parameter int DATA_W = 16;

    typedef enum logic [1:0] {
        S_IDLE,
        S_ARB,
        S_RDLAT,
        S_ACK
    } state_t;

    typedef struct packed {
        logic              wr;
        logic              ram;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } cmd_t;
endpackage

// File: rtl/shif_capture.sv
module shif_capture
    import shif_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              strb_n,
    input  logic              sel_n,
    input  logic              rw,
    input  logic              pol_strap,
    input  logic              mr_sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              start,
    output cmd_t              cmd
);
    logic strb_q;

    assign start = arm && strb_q && !strb_n && !sel_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strb_q <= 1'b1;
            cmd    <= '0;
        end else begin
            strb_q <= strb_n;
            if (start) begin
                cmd.wr   <= pol_strap ? rw : !rw;
                cmd.ram  <= mr_sel;
                cmd.addr <= addr;
                cmd.data <= wdata;
            end
        end
    end

    // R3: the captured access does not follow the bus after the start edge
    a_r3_cmd_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(cmd));
endmodule

// File: rtl/shif_arb.sv
module shif_arb #(
    parameter int MAX_WAIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hreq,
    input  logic cl_req,
    output logic h_gnt,
    output logic c_gnt
);
    localparam int CW = $clog2(MAX_WAIT + 2);

    logic [CW-1:0] wcnt;
    logic          force_h;

    assign force_h = (wcnt == CW'(MAX_WAIT));

    always_comb begin
        h_gnt = hreq && (!cl_req || force_h);
        c_gnt = cl_req && !h_gnt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            wcnt <= '0;
        else if (!hreq || h_gnt)
            wcnt <= '0;
        else
            wcnt <= wcnt + 1'b1;
    end

    // R8: the host is never denied more than MAX_WAIT cycles in a row
    a_r8_wait_bound: assert property (@(posedge clk) disable iff (!rst_n)
        wcnt <= CW'(MAX_WAIT));

    // R8: a denied host request always means the client holds the slot
    a_r8_client_served: assert property (@(posedge clk) disable iff (!rst_n)
        (hreq && !h_gnt) |-> (c_gnt && cl_req));
endmodule

// File: rtl/shif_regfile.sv
module shif_regfile
    import shif_pkg::*;
#(
    parameter int NREG = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [$clog2(NREG)-1:0] idx,
    input  logic [DATA_W-1:0]       wdata,
    output logic [DATA_W-1:0]       rdata
);
    logic [DATA_W-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (we && (idx == g))
                regs[g] <= wdata;
        end
    end

    assign rdata = regs[idx];
endmodule

// File: rtl/shif_top.sv
module shif_top
    import shif_pkg::*;
#(
    parameter int NREG     = 8,
    parameter int MAX_WAIT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              zw_strap,
    input  logic              pol_strap,
    input  logic              sel_n,
    input  logic              strb_n,
    input  logic              rw,
    input  logic              mr_sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              ready_n,
    input  logic              cl_req,
    input  logic              cl_we,
    input  logic [ADDR_W-1:0] cl_addr,
    input  logic [DATA_W-1:0] cl_wdata,
    output logic              cl_gnt,
    output logic [DATA_W-1:0] cl_rdata,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int IW = $clog2(NREG);

    state_t            state, nxt;
    cmd_t              cmd;
    logic              start, hreq, h_gnt, c_gnt, served, rel_q, reg_we;
    logic [DATA_W-1:0] reg_rdata, rd_hold;

    shif_capture u_cap (
        .clk(clk), .rst_n(rst_n), .arm(state == S_IDLE),
        .strb_n(strb_n), .sel_n(sel_n), .rw(rw), .pol_strap(pol_strap),
        .mr_sel(mr_sel), .addr(addr), .wdata(wdata),
        .start(start), .cmd(cmd)
    );

    shif_arb #(.MAX_WAIT(MAX_WAIT)) u_arb (
        .clk(clk), .rst_n(rst_n), .hreq(hreq), .cl_req(cl_req),
        .h_gnt(h_gnt), .c_gnt(c_gnt)
    );

    shif_regfile #(.NREG(NREG)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .idx(cmd.addr[IW-1:0]),
        .wdata(cmd.data), .rdata(reg_rdata)
    );

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (start) nxt = S_ARB;
            S_ARB:   if (served) nxt = !cmd.wr ? S_RDLAT : (zw_strap ? S_ACK : S_IDLE);
            S_RDLAT: nxt = zw_strap ? S_ACK : S_IDLE;
            S_ACK:   if (strb_n) nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // state register and data holding
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            rel_q   <= 1'b0;
            rd_hold <= '0;
        end else begin
            state <= nxt;
            if (nxt == S_IDLE)
                rel_q <= 1'b0;
            else if (state != S_IDLE && strb_n)
                rel_q <= 1'b1;
            if (state == S_RDLAT)
                rd_hold <= cmd.ram ? mem_rdata : reg_rdata;
        end
    end

    // outputs
    always_comb begin
        hreq      = (state == S_ARB) && cmd.ram;
        served    = (state == S_ARB) && (!cmd.ram || h_gnt);
        reg_we    = (state == S_ARB) && !cmd.ram && cmd.wr;
        if (zw_strap)
            ready_n = (state != S_ACK);
        else
            ready_n = (state == S_ARB || state == S_RDLAT) && (rel_q || strb_n);
        cl_gnt    = c_gnt;
        mem_en    = h_gnt || c_gnt;
        mem_we    = h_gnt ? cmd.wr : (c_gnt && cl_we);
        mem_addr  = h_gnt ? cmd.addr : cl_addr;
        mem_wdata = h_gnt ? cmd.data : cl_wdata;
    end

    assign rdata    = rd_hold;
    assign cl_rdata = mem_rdata;

    // R3: a captured start always leaves idle
    a_r3_start_taken: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (state == S_ARB));

    // R4: in acknowledged mode the handshake holds while the strobe is low
    a_r4_ack_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (zw_strap && !ready_n && !strb_n) |=> !ready_n);

    // R6: zero-wait handshake is high while a released access is unfinished
    a_r6_zw_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (!zw_strap && hreq && !h_gnt && strb_n) |-> ready_n);

    // R7: read data moves only at the end of a read fetch
    a_r7_rdata_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_RDLAT) |=> $stable(rdata));
endmodule

// File: tb/tb_shif_top.sv
module tb_shif_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        zw_strap = 1'b1, pol_strap = 1'b0;
    logic        sel_n = 1'b1, strb_n = 1'b1, rw = 1'b1, mr_sel = 1'b1;
    logic [13:0] addr = '0, cl_addr = '0;
    logic [15:0] wdata = '0, cl_wdata = '0;
    logic        cl_req = 1'b0, cl_we = 1'b0;
    logic [15:0] rdata, cl_rdata, mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic        ready_n, cl_gnt, mem_en, mem_we;
    logic [13:0] mem_addr;

    int          n_chk = 0, n_fail = 0;
    bit          finished = 0;
    logic [15:0] ram [int];
    logic [15:0] exp_ram [int];
    logic [15:0] exp_reg [8];
    logic [15:0] last_rd = '0;

    always #2 clk = ~clk;

    shif_top dut (
        .clk(clk), .rst_n(rst_n), .zw_strap(zw_strap), .pol_strap(pol_strap),
        .sel_n(sel_n), .strb_n(strb_n), .rw(rw), .mr_sel(mr_sel),
        .addr(addr), .wdata(wdata), .rdata(rdata), .ready_n(ready_n),
        .cl_req(cl_req), .cl_we(cl_we), .cl_addr(cl_addr), .cl_wdata(cl_wdata),
        .cl_gnt(cl_gnt), .cl_rdata(cl_rdata), .mem_en(mem_en), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // memory model: one cycle read latency
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we)
                ram[int'(mem_addr)] = mem_wdata;
            else
                mem_rdata <= ram.exists(int'(mem_addr)) ? ram[int'(mem_addr)] : 16'h0;
        end
    end

    function automatic logic [15:0] ram_get(input logic [13:0] a);
        return exp_ram.exists(int'(a)) ? exp_ram[int'(a)] : 16'h0;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // one host access, started at a negedge; burst<0 means random client load
    task automatic host_acc(input bit wr, input bit is_ram, input logic [13:0] a,
                            input logic [15:0] d, input int burst);
        int lat = 0, den = 0, kg = 1, expl;
        bit granted, done = 0, v;
        logic [15:0] ev;
        ev = is_ram ? ram_get(a) : exp_reg[a[2:0]];
        rw = pol_strap ? wr : !wr;
        mr_sel = is_ram; addr = a; wdata = d; sel_n = 0; strb_n = 0; cl_req = 0;
        granted = !is_ram;
        for (int k = 1; k <= 60 && !done; k++) begin
            @(negedge clk);
            if (k > 1 && !ready_n) begin
                done = 1; lat = k;
            end
            if (k == 1) begin
                if (!zw_strap) begin
                    chk(ready_n == 0, "R6 ready low while strobe held", 32'(ready_n), 0);
                    chk(rdata == last_rd, "R7 previous read data", 32'(rdata), 32'(last_rd));
                end
                addr = 14'($urandom); wdata = 16'($urandom);   // R3 bus scramble
                rw = 1'($urandom); mr_sel = 1'($urandom);
                if (!zw_strap) begin
                    strb_n = 1; sel_n = 1; #1;
                    chk(ready_n == 1, "R6 ready high after release", 32'(ready_n), 1);
                end
            end
            if (!done) begin
                v = (burst < 0) ? 1'($urandom) : (k <= burst);
                cl_req = v; cl_addr = 14'($urandom);
                if (!granted) begin
                    if (v && den < 4) begin
                        chk(cl_gnt == 1 || k == 1, "R8 client granted", 32'(cl_gnt), 1);
                        den++;
                    end else begin
                        granted = 1; kg = k;
                    end
                end
            end
        end
        expl = kg + (wr ? 1 : 2);
        chk(lat == expl, "R4/R5/R6/R8 ready latency", 32'(lat), 32'(expl));
        if (!wr)
            chk(rdata == ev, zw_strap ? "R5 read data" : "R7 completed read data",
                32'(rdata), 32'(ev));
        cl_req = 0;
        if (zw_strap) begin
            strb_n = 1; sel_n = 1;
            @(negedge clk);
            chk(ready_n == 1, "R4 ready high after release", 32'(ready_n), 1);
        end
        if (wr) begin
            if (is_ram) exp_ram[int'(a)] = d;
            else exp_reg[a[2:0]] = d;
        end else
            last_rd = ev;
    endtask

    initial begin
        #800000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        bit wr, rm;
        logic [13:0] a;
        for (int i = 0; i < 8; i++) exp_reg[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R10 reset state
        chk(ready_n == 1, "R10 ready after reset", 32'(ready_n), 1);
        chk(rdata == 0, "R10 rdata after reset", 32'(rdata), 0);
        zw_strap = 0; #1;
        chk(ready_n == 0, "R6 idle ready rests low", 32'(ready_n), 0);
        zw_strap = 1;
        @(negedge clk);

        // R9 register reset value
        host_acc(0, 0, 14'd3, 16'h0, 0);
        // R1 R2 memory boundaries, both polarities
        host_acc(1, 1, 14'h0000, 16'h1234, 0);
        host_acc(1, 1, 14'h3FFF, 16'hBEEF, 0);
        host_acc(0, 1, 14'h0000, 16'h0, 0);
        host_acc(0, 1, 14'h3FFF, 16'h0, 0);
        pol_strap = 1;
        host_acc(1, 1, 14'h0007, 16'hA5A5, 0);
        host_acc(0, 1, 14'h0007, 16'h0, 0);
        pol_strap = 0;
        // R1 R9 register with upper address bits set
        host_acc(1, 0, 14'h3FF5, 16'hC0DE, 0);
        host_acc(0, 0, 14'h0005, 16'h0, 0);
        host_acc(0, 1, 14'h3FF5, 16'h0, 0);
        // R8 contention: capped and short bursts
        host_acc(1, 1, 14'h0010, 16'h5151, 10);
        host_acc(0, 1, 14'h0010, 16'h0, 10);
        host_acc(0, 1, 14'h0007, 16'h0, 2);
        host_acc(1, 0, 14'h0002, 16'h7777, 10);

        // zero-wait mode: pipelined reads (R7)
        zw_strap = 0;
        host_acc(1, 1, 14'h0020, 16'h2020, 0);
        host_acc(0, 1, 14'h0020, 16'h0, 0);
        host_acc(0, 1, 14'h3FFF, 16'h0, 3);
        host_acc(0, 0, 14'h0002, 16'h0, 0);

        // R6 strobe held long: ready stays low throughout
        rw = 1; mr_sel = 1; addr = 14'h0021; sel_n = 0; strb_n = 0;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk(ready_n == 0, "R6 held strobe ready low", 32'(ready_n), 0);
        end
        strb_n = 1; sel_n = 1; #1;
        chk(ready_n == 0, "R6 ready low after late release", 32'(ready_n), 0);
        last_rd = ram_get(14'h0021);
        @(negedge clk);

        // R3 a strobe fall while busy is ignored
        cl_req = 1;
        rw = 0; mr_sel = 1; addr = 14'h0100; wdata = 16'hAAAA; sel_n = 0; strb_n = 0;
        @(negedge clk);
        strb_n = 1; sel_n = 1;
        @(negedge clk);
        addr = 14'h0200; wdata = 16'h5555; rw = 0; sel_n = 0; strb_n = 0;
        for (int k = 0; k < 12 && ready_n; k++) @(negedge clk);
        cl_req = 0;
        repeat (3) @(negedge clk);
        strb_n = 1; sel_n = 1;
        @(negedge clk);
        exp_ram[int'(14'h0100)] = 16'hAAAA;
        zw_strap = 1;
        host_acc(0, 1, 14'h0100, 16'h0, 0);
        host_acc(0, 1, 14'h0200, 16'h0, 0);

        // random mix, fixed seed
        void'($urandom(32'd773));
        for (int i = 0; i < 200; i++) begin
            zw_strap = 1'($urandom);
            pol_strap = 1'($urandom);
            wr = 1'($urandom);
            rm = ($urandom % 4) != 0;
            a = (($urandom % 5) == 0) ? 14'h3FFF : 14'($urandom % 16);
            host_acc(wr, rm, a, 16'($urandom), -1);
        end
        finish_run();
    end
endmodule